// File: doc/BRIEF.md
# Debug Request Handshake Controller

This block combines three debug-entry sources into one request to a processor core. The sources are a software request, a maskable hardware request line, and a breakpoint match. The block then holds that request until the core acknowledges that it has entered debug. It also produces a breakpoint request for the current bus access. When a request is raised while the core sits in a low-power state, it emits a one-cycle wake pulse. Sticky status bits record which sources caused an entry, and they also expose the acknowledge state.

Software drives a small control write port. In a write word, bit 0 asks for debug entry and bit 1 enables the hardware request line. Software clears status bits by writing ones to them. Every output is registered. Reset is synchronous and active low.

Top module: `dbg_req_hs`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output goes to 0 after that edge, and this includes the hardware-line enable `hw_en_o`.
- R2: A cycle with `cfg_we`=1 and `cfg_wdata[0]`=1 raises `dbg_req_o` after the next edge and sets `stat_src_o[0]`.
- R3: A cycle with `cfg_we`=1 loads `cfg_wdata[1]` into `hw_en_o` after the edge. While `hw_en_o` is 1, `hw_dbg_req`=1 raises `dbg_req_o` after the next edge and sets `stat_src_o[1]`, exactly as a software request would.
- R4: While `hw_en_o` is 0, `hw_dbg_req` has no effect on `dbg_req_o` or `stat_src_o`.
- R5: `bkpt_hit`=1 gives `bkpt_req_o`=1 one cycle later, for one cycle per hit cycle. It also raises `dbg_req_o` and sets `stat_src_o[2]`.
- R6: Once `dbg_req_o` is high, it stays high until an edge at which `core_ack`=1 is sampled, and it is 0 after that edge.
- R7: Any trigger that arrives in a cycle with `core_ack`=1 is ignored, so neither the request nor the status changes.
- R8: `stat_ack_o` equals the value `core_ack` had at the previous edge.
- R9: A 1 in `stat_clr[i]` clears `stat_src_o[i]` after the edge. If a trigger sets the same bit in the same cycle, the set wins.
- R10: `wake_o` is high for exactly the first cycle of a new request, and only if some bit of `lp_state` was 1 in the triggering cycle.
- R11: Sources that trigger in the same cycle set all of their status bits and produce a single held request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_wdata | input | 2 | Bit 0 requests debug entry; bit 1 is the hardware-line enable |
| stat_clr | input | 3 | Write-one-to-clear for the status bits |
| hw_dbg_req | input | 1 | Hardware debug request line |
| bkpt_hit | input | 1 | Breakpoint match for the current bus access |
| core_ack | input | 1 | Core acknowledges that it is in debug |
| lp_state | input | LP_W | Core low-power status (stop, doze, wait) |
| dbg_req_o | output | 1 | Held debug request to the core |
| bkpt_req_o | output | 1 | Breakpoint request |
| wake_o | output | 1 | One-cycle wake pulse |
| stat_src_o | output | 3 | Sticky source bits: 0 software, 1 hardware line, 2 breakpoint |
| stat_ack_o | output | 1 | Registered acknowledge state |
| hw_en_o | output | 1 | Current hardware-line enable |

## Verification
Every result of this block is due exactly one clock edge after the inputs that cause it. This covers the request rise and fall, the breakpoint request, the wake pulse, the status set and clear, and the mask update. The driver applies each stimulus on the falling edge and queues the expected output word for that cycle. The monitor then compares that word just after the following rising edge, so every comparison lands on the cycle in which the output changes. Held and ignored cases also get one queued word per idle cycle, which catches a request that drops early or a status bit that sets when it should not.

// File: rtl/dbg_hs_pkg.sv
package dbg_hs_pkg;
    localparam int SRC_W  = 3;
    localparam int SRC_SW = 0;
    localparam int SRC_HW = 1;
    localparam int SRC_BP = 2;
    localparam int CFG_W  = 2;
    localparam int CFG_REQ = 0;
    localparam int CFG_EN  = 1;

    typedef struct packed {
        logic             req;
        logic             bkpt;
        logic             wake;
        logic [SRC_W-1:0] src;
        logic             ack;
        logic             mask;
    } hs_state_t;
endpackage

// File: rtl/dbg_src_merge.sv
module dbg_src_merge
    import dbg_hs_pkg::*;
(
    input  logic             sw_set,
    input  logic             hw_line,
    input  logic             hw_en,
    input  logic             bkpt_hit,
    input  logic             core_ack,
    output logic [SRC_W-1:0] trig
);
    logic [SRC_W-1:0] raw;

    always_comb begin
        raw         = '0;
        raw[SRC_SW] = sw_set;
        raw[SRC_HW] = hw_line & hw_en;
        raw[SRC_BP] = bkpt_hit;
        // no new entry is queued while the core is already in debug
        trig        = core_ack ? '0 : raw;
    end
endmodule

// File: rtl/dbg_hs_regs.sv
module dbg_hs_regs
    import dbg_hs_pkg::*;
#(
    parameter int LP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] trig,
    input  logic [SRC_W-1:0] clr,
    input  logic             core_ack,
    input  logic             bkpt_hit,
    input  logic [LP_W-1:0]  lp,
    input  logic             mask_we,
    input  logic             mask_val,
    output hs_state_t        st_q
);
    hs_state_t st_d;

    always_comb begin
        st_d      = st_q;
        st_d.bkpt = bkpt_hit;
        st_d.ack  = core_ack;
        if (mask_we) begin
            st_d.mask = mask_val;
        end
        if (core_ack) begin
            st_d.req = 1'b0;
        end else if (|trig) begin
            st_d.req = 1'b1;
        end
        st_d.src  = (st_q.src & ~clr) | trig;
        st_d.wake = st_d.req & ~st_q.req & (|lp);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/dbg_req_hs.sv
module dbg_req_hs
    import dbg_hs_pkg::*;
#(
    parameter int LP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic [SRC_W-1:0] stat_clr,
    input  logic             hw_dbg_req,
    input  logic             bkpt_hit,
    input  logic             core_ack,
    input  logic [LP_W-1:0]  lp_state,
    output logic             dbg_req_o,
    output logic             bkpt_req_o,
    output logic             wake_o,
    output logic [SRC_W-1:0] stat_src_o,
    output logic             stat_ack_o,
    output logic             hw_en_o
);
    logic [SRC_W-1:0] trig;
    hs_state_t        st_q;

    dbg_src_merge u_merge (
        .sw_set   (cfg_we & cfg_wdata[CFG_REQ]),
        .hw_line  (hw_dbg_req),
        .hw_en    (st_q.mask),
        .bkpt_hit (bkpt_hit),
        .core_ack (core_ack),
        .trig     (trig)
    );

    dbg_hs_regs #(.LP_W(LP_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (trig),
        .clr      (stat_clr),
        .core_ack (core_ack),
        .bkpt_hit (bkpt_hit),
        .lp       (lp_state),
        .mask_we  (cfg_we),
        .mask_val (cfg_wdata[CFG_EN]),
        .st_q     (st_q)
    );

    assign dbg_req_o  = st_q.req;
    assign bkpt_req_o = st_q.bkpt;
    assign wake_o     = st_q.wake;
    assign stat_src_o = st_q.src;
    assign stat_ack_o = st_q.ack;
    assign hw_en_o    = st_q.mask;
endmodule

// File: rtl/dbg_req_hs_chk.sv
module dbg_req_hs_chk (
    input logic clk,
    input logic rst_n,
    input logic core_ack,
    input logic bkpt_hit,
    input logic dbg_req_o,
    input logic bkpt_req_o,
    input logic wake_o,
    input logic stat_ack_o
);
    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_req_o && !core_ack) |=> dbg_req_o);
    // R6
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_ack |=> !dbg_req_o);
    // R7
    ack_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_ack && !dbg_req_o) |=> !dbg_req_o);
    // R5
    bkpt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bkpt_hit |=> bkpt_req_o);
    // R8
    ack_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_ack |=> stat_ack_o);
    // R8
    ack_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_ack |=> !stat_ack_o);
    // R10
    wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);
    // R10
    wake_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (dbg_req_o && !$past(dbg_req_o)));
endmodule

bind dbg_req_hs dbg_req_hs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_ack   (core_ack),
    .bkpt_hit   (bkpt_hit),
    .dbg_req_o  (dbg_req_o),
    .bkpt_req_o (bkpt_req_o),
    .wake_o     (wake_o),
    .stat_ack_o (stat_ack_o)
);

// File: tb/sim_dbg_req_hs.sv
`timescale 1ns/1ps
module sim_dbg_req_hs;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we;
    logic [1:0] cfg_wdata;
    logic [2:0] stat_clr;
    logic       hw_dbg_req, bkpt_hit, core_ack;
    logic [2:0] lp_state;
    logic       dbg_req_o, bkpt_req_o, wake_o, stat_ack_o, hw_en_o;
    logic [2:0] stat_src_o;

    typedef struct {
        logic [7:0] val;   // {req,bkpt,wake,src[2:0],ack,en}
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    int checks = 0, fails = 0, cycles = 0;
    logic       m_req, m_en;
    logic [2:0] m_src;

    always #4 clk = ~clk;

    dbg_req_hs u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .stat_clr(stat_clr), .hw_dbg_req(hw_dbg_req), .bkpt_hit(bkpt_hit),
        .core_ack(core_ack), .lp_state(lp_state), .dbg_req_o(dbg_req_o),
        .bkpt_req_o(bkpt_req_o), .wake_o(wake_o), .stat_src_o(stat_src_o),
        .stat_ack_o(stat_ack_o), .hw_en_o(hw_en_o)
    );

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0; cfg_we = 0; cfg_wdata = 0; stat_clr = 0;
        hw_dbg_req = 0; bkpt_hit = 0; core_ack = 0; lp_state = 0;
        m_req = 0; m_en = 0; m_src = 0;
        exp_q.push_back('{8'h00, tag});
    endtask

    task automatic drv(input logic we, input logic [1:0] wd, input logic hw,
                       input logic bp, input logic ack, input logic [2:0] lp,
                       input logic [2:0] clr, input string tag);
        logic [2:0] t;
        logic       n_req, wk;
        @(negedge clk);
        rst_n = 1'b1; cfg_we = we; cfg_wdata = wd; hw_dbg_req = hw;
        bkpt_hit = bp; core_ack = ack; lp_state = lp; stat_clr = clr;
        t = ack ? 3'b000 : {bp, hw & m_en, we & wd[0]};
        n_req = ack ? 1'b0 : ((|t) ? 1'b1 : m_req);
        wk = n_req & ~m_req & (|lp);
        m_src = (m_src & ~clr) | t;
        m_req = n_req;
        if (we) m_en = wd[1];
        exp_q.push_back('{{m_req, bp, wk, m_src, ack, m_en}, tag});
    endtask

    task automatic idle(input logic ack, input string tag);
        drv(0, 2'b00, 0, 0, ack, 3'b000, 3'b000, tag);
    endtask

    // monitor: compare just after each rising edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            logic [7:0] act;
            e = exp_q.pop_front();
            act = {dbg_req_o, bkpt_req_o, wake_o, stat_src_o, stat_ack_o, hw_en_o};
            checks++;
            if (act !== e.val) begin
                fails++;
                $display("FAIL %s: actual %b expected %b", e.tag, act, e.val);
            end
        end
    end

    initial begin
        do_reset("R1 reset");
        do_reset("R1 reset hold");
        idle(0, "R1 idle after reset");
        // software request
        drv(1, 2'b01, 0, 0, 0, 3'b000, 3'b000, "R2 sw request");
        idle(0, "R6 hold 1");
        idle(0, "R6 hold 2");
        idle(1, "R6 drop on ack / R8");
        drv(1, 2'b01, 0, 1, 1, 3'b000, 3'b000, "R7 ignored during ack");
        idle(0, "R8 ack low");
        drv(0, 2'b00, 0, 0, 0, 3'b000, 3'b001, "R9 clear sw bit");
        // masked hardware line
        drv(0, 2'b00, 1, 0, 0, 3'b000, 3'b000, "R4 hw masked");
        drv(0, 2'b00, 1, 0, 0, 3'b111, 3'b000, "R4 hw masked lp");
        drv(1, 2'b10, 1, 0, 0, 3'b000, 3'b000, "R3 enable write");
        drv(0, 2'b00, 1, 0, 0, 3'b001, 3'b000, "R3 hw request / R10 wake");
        idle(0, "R10 wake single");
        idle(1, "R6 ack");
        idle(0, "R8 ack released");
        drv(0, 2'b00, 0, 0, 0, 3'b000, 3'b010, "R9 clear hw bit");
        // breakpoint
        drv(0, 2'b00, 0, 1, 0, 3'b000, 3'b000, "R5 bkpt no wake");
        idle(0, "R5 bkpt one cycle");
        idle(1, "R6 ack bkpt");
        idle(0, "R6 idle");
        // all sources together
        drv(1, 2'b11, 1, 1, 0, 3'b100, 3'b000, "R11 combined / R10");
        idle(0, "R11 single request");
        drv(0, 2'b00, 0, 1, 0, 3'b000, 3'b111, "R9 set wins over clear");
        idle(1, "R6 ack combined");
        drv(0, 2'b00, 0, 0, 0, 3'b000, 3'b100, "R9 clear bp bit");
        drv(1, 2'b00, 1, 0, 0, 3'b000, 3'b000, "R3 disable write");
        drv(0, 2'b00, 1, 0, 0, 3'b000, 3'b000, "R4 hw masked again");
        do_reset("R1 reset clears state");
        idle(0, "R1 final");
        @(negedge clk);
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000) begin
                checks++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
                $finish;
            end
        end
    end
endmodule